// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This unit watches the instruction stream of a small processor and flags a breakpoint when the fetch address hits a programmed value. The fetch address is 24 bits wide: an 8-bit bank number on top of a 16-bit program counter. On every fetch strobe it is compared with two programmable 24-bit compare registers. When detection is enabled and the comparison chosen by the mode input succeeds, the unit emits a one-cycle interrupt request. In the dual-address mode it also records which of the two registers produced the hit.

Software reaches the unit through a byte-wide register port. One control byte sits at 0x67 and six compare bytes sit at 0x68 to 0x6D. Software must raise an access-enable bit in the control byte before it touches the compare bytes, and drop it again afterwards. Power-on reset clears all state. A warm reset (hardware or software) leaves the control byte and compare registers untouched and only silences the unit while it is asserted.

Top module: `brkpt_match_unit`

## Requirements
- R1: Power-on reset (`por_rst` high at a clock edge) clears every control bit and all six compare bytes to 0, and `irq` reads 0.
- R2: While `warm_rst` is high, register writes are ignored and no interrupt is raised, and the control byte and compare bytes keep their values across the warm reset.
- R3: The control byte at 0x67 reads as {0, decision, detect-enable, attach, hold-one, access-enable, 0, reserved-zero}, from bit 7 down to bit 0. Bits 0, 2, 3 and 5 are writable and read back. Bits 1 and 7 read 0. Bit 4 shows the `dbg_attached` input. Bit 6 cannot be written.
- R4: With bit 2 set, bytes 0x68, 0x69 and 0x6A hold PC bits [7:0], PC bits [15:8] and the bank of compare register 0. Bytes 0x6B, 0x6C and 0x6D hold the same fields of compare register 1. All six can be written and read back.
- R5: With bit 2 clear, writes to 0x68 to 0x6D are ignored and reads from them return 0x00.
- R6: In mode 0, when bit 5 is set, a fetch whose {bank, PC} equals compare register 0 makes `irq` high for exactly one cycle, starting at the clock edge that samples the fetch. A fetch that matches only register 1 raises nothing.
- R7: In mode 1, only a match with compare register 1 raises the one-cycle `irq` pulse.
- R8: In mode 2, a match with either register raises `irq`. On that edge the decision bit (bit 6) becomes 0 for a register-0 match and 1 for a register-1 match. Register 0 wins when both registers match.
- R9: In modes 0, 1 and 3 the decision bit keeps its value, even when a fetch raises `irq`.
- R10: With bit 5 clear, or in mode 3, no fetch raises `irq`.
- R11: Register reads from any address outside 0x67 to 0x6D return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high; clears all state |
| warm_rst | input | 1 | Hardware/software reset, synchronous, active high; keeps state, blocks writes and detection |
| reg_addr | input | 8 | Register port byte address |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| dbg_attached | input | 1 | High while an external debugger is connected |
| mode | input | 2 | Detection mode: 0 register 0, 1 register 1, 2 both, 3 off |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_bank | input | 8 | Bank of the fetch address |
| fetch_pc | input | 16 | Program counter of the fetch address |
| irq | output | 1 | Breakpoint interrupt request, one-cycle pulse |

## Verification
The assertions assume that `por_rst` is high from time zero until after the first clock edge, so the decision and interrupt registers are never judged on values from before reset. They also assume that `mode` and the fetch inputs are stable around each sampling edge. The bench drives every input on the falling edge and holds power-on reset for several cycles at the start, which keeps both conditions true. The warm-reset assertion relies on a warm reset never overlapping a power-on reset, and the bench keeps the two apart.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;

    localparam int BUS_W         = 8;
    localparam int BANK_W        = 8;
    localparam int PC_W          = 16;
    localparam int FETCH_W       = BANK_W + PC_W;
    localparam int NUM_CMP       = 2;
    localparam int BYTES_PER_CMP = FETCH_W / BUS_W;
    localparam int NUM_CMP_BYTES = NUM_CMP * BYTES_PER_CMP;

    localparam logic [BUS_W-1:0] CTRL_ADDR = 8'h67;
    localparam logic [BUS_W-1:0] CMP_BASE  = 8'h68;

    // control byte bit positions
    localparam int BIT_RSVD0 = 0;
    localparam int BIT_ACC   = 2;
    localparam int BIT_KEEP1 = 3;
    localparam int BIT_DBG   = 4;
    localparam int BIT_DET   = 5;
    localparam int BIT_DEC   = 6;

    typedef enum logic [1:0] {
        MODE_REG0 = 2'd0,
        MODE_REG1 = 2'd1,
        MODE_DUAL = 2'd2,
        MODE_OFF  = 2'd3
    } det_mode_e;

    typedef struct packed {
        logic dec;
        logic det_en;
        logic keep1;
        logic acc_en;
        logic rsvd0;
    } ctrl_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [PC_W-1:0]   pc;
    } fetch_addr_t;

    function automatic logic in_cmp_window(input logic [BUS_W-1:0] a);
        return (int'(a) >= int'(CMP_BASE)) &&
               (int'(a) <  int'(CMP_BASE) + NUM_CMP_BYTES);
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_view(input ctrl_t c, input logic dbg);
        logic [BUS_W-1:0] v;
        v            = '0;
        v[BIT_RSVD0] = c.rsvd0;
        v[BIT_ACC]   = c.acc_en;
        v[BIT_KEEP1] = c.keep1;
        v[BIT_DBG]   = dbg;
        v[BIT_DET]   = c.det_en;
        v[BIT_DEC]   = c.dec;
        return v;
    endfunction

endpackage

// File: rtl/brkpt_ctrl_reg.sv
module brkpt_ctrl_reg
    import brkpt_pkg::*;
(
    input  logic             clk,
    input  logic             por_rst,
    input  logic             warm_rst,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    input  logic             dec_load,
    input  logic             dec_val,
    output ctrl_t            ctrl_q
);

    // Only power-on reset clears; warm reset freezes the register.
    always_ff @(posedge clk) begin
        if (por_rst) begin
            ctrl_q <= '0;
        end else if (!warm_rst) begin
            if (wr_en) begin
                ctrl_q.rsvd0  <= wdata[BIT_RSVD0];
                ctrl_q.acc_en <= wdata[BIT_ACC];
                ctrl_q.keep1  <= wdata[BIT_KEEP1];
                ctrl_q.det_en <= wdata[BIT_DET];
            end
            if (dec_load) begin
                ctrl_q.dec <= dec_val;
            end
        end
    end

endmodule

// File: rtl/brkpt_cmp_file.sv
module brkpt_cmp_file
    import brkpt_pkg::*;
(
    input  logic                              clk,
    input  logic                              por_rst,
    input  logic                              wr_en,
    input  logic [BUS_W-1:0]                  addr,
    input  logic [BUS_W-1:0]                  wdata,
    output logic [NUM_CMP-1:0][FETCH_W-1:0]   cmp_vals,
    output logic [BUS_W-1:0]                  rd_byte
);

    logic [NUM_CMP_BYTES-1:0][BUS_W-1:0] bytes_q;
    logic [BUS_W-1:0]                    offset;

    assign offset = addr - CMP_BASE;

    for (genvar k = 0; k < NUM_CMP_BYTES; k++) begin : g_byte
        always_ff @(posedge clk) begin
            if (por_rst) begin
                bytes_q[k] <= '0;
            end else if (wr_en && offset == BUS_W'(k)) begin
                bytes_q[k] <= wdata;
            end
        end
    end

    // Byte 0 of each register is the least significant slice.
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_reg
        for (genvar b = 0; b < BYTES_PER_CMP; b++) begin : g_slice
            assign cmp_vals[g][b*BUS_W +: BUS_W] = bytes_q[g*BYTES_PER_CMP + b];
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int k = 0; k < NUM_CMP_BYTES; k++) begin
            if (offset == BUS_W'(k)) begin
                rd_byte = bytes_q[k];
            end
        end
    end

endmodule

// File: rtl/brkpt_matcher.sv
module brkpt_matcher
    import brkpt_pkg::*;
(
    input  logic                            clk,
    input  logic                            por_rst,
    input  logic                            warm_rst,
    input  logic                            fetch_valid,
    input  fetch_addr_t                     fetch_addr,
    input  logic [NUM_CMP-1:0][FETCH_W-1:0] cmp_vals,
    input  det_mode_e                       mode,
    input  logic                            det_en,
    output logic                            irq,
    output logic                            dec_load,
    output logic                            dec_val
);

    logic [NUM_CMP-1:0] hit;
    logic               sel_hit;
    logic               dual;
    logic               fire;

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        assign hit[g] = (fetch_addr == cmp_vals[g]);
    end

    always_comb begin
        dual    = 1'b0;
        sel_hit = 1'b0;
        case (mode)
            MODE_REG0: sel_hit = hit[0];
            MODE_REG1: sel_hit = hit[1];
            MODE_DUAL: begin
                sel_hit = |hit;
                dual    = 1'b1;
            end
            default:   sel_hit = 1'b0;
        endcase
    end

    assign fire     = fetch_valid & det_en & sel_hit & ~warm_rst;
    assign dec_load = fire & dual;
    assign dec_val  = ~hit[0];   // register 0 wins a tie

    always_ff @(posedge clk) begin
        if (por_rst) begin
            irq <= 1'b0;
        end else begin
            irq <= fire;
        end
    end

endmodule

// File: rtl/brkpt_match_unit.sv
module brkpt_match_unit
    import brkpt_pkg::*;
(
    input  logic        clk,
    input  logic        por_rst,
    input  logic        warm_rst,
    input  logic [7:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        dbg_attached,
    input  logic [1:0]  mode,
    input  logic        fetch_valid,
    input  logic [7:0]  fetch_bank,
    input  logic [15:0] fetch_pc,
    output logic        irq
);

    ctrl_t                           ctrl_q;
    logic                            det_en;
    logic                            acc_en;
    logic                            decision;
    logic                            ctrl_wr;
    logic                            cmp_wr;
    logic                            cmp_sel;
    logic                            dec_load;
    logic                            dec_val;
    logic [BUS_W-1:0]                cmp_rd;
    logic [NUM_CMP-1:0][FETCH_W-1:0] cmp_vals;
    fetch_addr_t                     fetch_addr;

    assign det_en   = ctrl_q.det_en;
    assign acc_en   = ctrl_q.acc_en;
    assign decision = ctrl_q.dec;

    assign fetch_addr.bank = fetch_bank;
    assign fetch_addr.pc   = fetch_pc;

    assign cmp_sel = in_cmp_window(reg_addr);
    assign ctrl_wr = reg_wr & ~warm_rst & (reg_addr == CTRL_ADDR);
    assign cmp_wr  = reg_wr & ~warm_rst & cmp_sel & acc_en;

    brkpt_ctrl_reg i_ctrl (
        .clk      (clk),
        .por_rst  (por_rst),
        .warm_rst (warm_rst),
        .wr_en    (ctrl_wr),
        .wdata    (reg_wdata),
        .dec_load (dec_load),
        .dec_val  (dec_val),
        .ctrl_q   (ctrl_q)
    );

    brkpt_cmp_file i_cmp (
        .clk      (clk),
        .por_rst  (por_rst),
        .wr_en    (cmp_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .cmp_vals (cmp_vals),
        .rd_byte  (cmp_rd)
    );

    brkpt_matcher i_match (
        .clk         (clk),
        .por_rst     (por_rst),
        .warm_rst    (warm_rst),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .cmp_vals    (cmp_vals),
        .mode        (det_mode_e'(mode)),
        .det_en      (det_en),
        .irq         (irq),
        .dec_load    (dec_load),
        .dec_val     (dec_val)
    );

    always_comb begin
        if (reg_addr == CTRL_ADDR) begin
            reg_rdata = ctrl_view(ctrl_q, dbg_attached);
        end else if (cmp_sel && acc_en) begin
            reg_rdata = cmp_rd;
        end else begin
            reg_rdata = '0;
        end
    end

endmodule

// File: rtl/brkpt_match_chk.sv
module brkpt_match_chk
    import brkpt_pkg::*;
(
    input logic       clk,
    input logic       por_rst,
    input logic       warm_rst,
    input logic [7:0] reg_addr,
    input logic [7:0] reg_rdata,
    input logic       dbg_attached,
    input logic [1:0] mode,
    input logic       fetch_valid,
    input logic       irq,
    input logic       det_en,
    input logic       acc_en,
    input logic       decision
);

    // R6
    irq_needs_fetch_chk: assert property (@(posedge clk) disable iff (por_rst)
        irq |-> $past(fetch_valid && det_en));

    // R2
    warm_silent_chk: assert property (@(posedge clk) disable iff (por_rst)
        $past(warm_rst) |-> !irq);

    // R9
    dec_hold_chk: assert property (@(posedge clk) disable iff (por_rst)
        !(mode == 2'd2 && fetch_valid) |=> $stable(decision));

    // R8
    dec_set_dual_chk: assert property (@(posedge clk) disable iff (por_rst)
        $rose(decision) |-> $past(mode == 2'd2 && fetch_valid));

    // R5
    locked_read_chk: assert property (@(posedge clk) disable iff (por_rst)
        (!acc_en && in_cmp_window(reg_addr)) |-> reg_rdata == 8'h00);

    // R3
    ctrl_fixed_bits_chk: assert property (@(posedge clk) disable iff (por_rst)
        (reg_addr == CTRL_ADDR) |->
            (!reg_rdata[7] && !reg_rdata[1] && reg_rdata[BIT_DBG] == dbg_attached));

endmodule

bind brkpt_match_unit brkpt_match_chk i_brkpt_match_chk (
    .clk          (clk),
    .por_rst      (por_rst),
    .warm_rst     (warm_rst),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .dbg_attached (dbg_attached),
    .mode         (mode),
    .fetch_valid  (fetch_valid),
    .irq          (irq),
    .det_en       (det_en),
    .acc_en       (acc_en),
    .decision     (decision)
);

// File: tb/test_brkpt_match_unit.sv
module test_brkpt_match_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        warm_rst = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        dbg_attached = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        fetch_valid = 1'b0;
    logic [7:0]  fetch_bank = 8'h00;
    logic [15:0] fetch_pc = 16'h0000;
    logic        irq;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    localparam logic [7:0]  A_BANK = 8'h12;
    localparam logic [15:0] A_PC   = 16'h3456;
    localparam logic [7:0]  B_BANK = 8'h9A;
    localparam logic [15:0] B_PC   = 16'hBCDE;

    always #(CLK_PERIOD/2) clk = ~clk;

    brkpt_match_unit i_brkpt_match_unit (
        .clk          (clk),
        .por_rst      (por_rst),
        .warm_rst     (warm_rst),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .dbg_attached (dbg_attached),
        .mode         (mode),
        .fetch_valid  (fetch_valid),
        .fetch_bank   (fetch_bank),
        .fetch_pc     (fetch_pc),
        .irq          (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, $sformatf("read 0x%0h", a), 32'(d), 32'(exp));
    endtask

    // irq is sampled one falling edge after the fetch, then one more later.
    task automatic fetch(input logic [7:0] bank, input logic [15:0] pc,
                         output logic pulse, output logic after);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_bank  = bank;
        fetch_pc    = pc;
        @(negedge clk);
        fetch_valid = 1'b0;
        pulse = irq;
        @(negedge clk);
        after = irq;
    endtask

    task automatic set_cmp(input int idx, input logic [7:0] bank, input logic [15:0] pc);
        wr(8'(8'h68 + 3*idx), pc[7:0]);
        wr(8'(8'h69 + 3*idx), pc[15:8]);
        wr(8'(8'h6A + 3*idx), bank);
    endtask

    task automatic t_por_state();
        chk("R1", "irq after power-on", 32'(irq), 32'h0);
        rd_chk("R1", 8'h67, 8'h00);
        wr(8'h67, 8'h0C);
        for (int k = 0; k < 6; k++) rd_chk("R1", 8'(8'h68 + k), 8'h00);
    endtask

    task automatic t_ctrl_layout();
        wr(8'h67, 8'hFF);
        rd_chk("R3", 8'h67, 8'h2D);
        dbg_attached = 1'b1;
        rd_chk("R3", 8'h67, 8'h3D);
        dbg_attached = 1'b0;
    endtask

    task automatic t_cmp_rw();
        wr(8'h67, 8'h0C);
        set_cmp(0, A_BANK, A_PC);
        set_cmp(1, B_BANK, B_PC);
        rd_chk("R4", 8'h68, 8'h56);
        rd_chk("R4", 8'h69, 8'h34);
        rd_chk("R4", 8'h6A, 8'h12);
        rd_chk("R4", 8'h6B, 8'hDE);
        rd_chk("R4", 8'h6C, 8'hBC);
        rd_chk("R4", 8'h6D, 8'h9A);
    endtask

    task automatic t_locked();
        wr(8'h67, 8'h08);
        wr(8'h68, 8'hAA);
        rd_chk("R5", 8'h68, 8'h00);
        rd_chk("R5", 8'h6D, 8'h00);
        wr(8'h67, 8'h0C);
        rd_chk("R5", 8'h68, 8'h56);
    endtask

    task automatic t_unmapped();
        rd_chk("R11", 8'h66, 8'h00);
        rd_chk("R11", 8'h6E, 8'h00);
        rd_chk("R11", 8'h00, 8'h00);
    endtask

    task automatic t_mode_reg0();
        logic p, a;
        wr(8'h67, 8'h28);
        mode = 2'd0;
        fetch(A_BANK, A_PC, p, a);
        chk("R6", "mode0 reg0 pulse", 32'(p), 32'h1);
        chk("R6", "mode0 pulse width", 32'(a), 32'h0);
        fetch(B_BANK, B_PC, p, a);
        chk("R6", "mode0 ignores reg1", 32'(p), 32'h0);
        fetch(A_BANK, A_PC ^ 16'h0001, p, a);
        chk("R6", "mode0 near miss", 32'(p), 32'h0);
    endtask

    task automatic t_mode_reg1();
        logic p, a;
        mode = 2'd1;
        fetch(B_BANK, B_PC, p, a);
        chk("R7", "mode1 reg1 pulse", 32'(p), 32'h1);
        chk("R7", "mode1 pulse width", 32'(a), 32'h0);
        fetch(A_BANK, A_PC, p, a);
        chk("R7", "mode1 ignores reg0", 32'(p), 32'h0);
    endtask

    task automatic t_dual();
        logic p, a;
        mode = 2'd2;
        fetch(B_BANK, B_PC, p, a);
        chk("R8", "dual reg1 pulse", 32'(p), 32'h1);
        rd_chk("R8", 8'h67, 8'h68);
        fetch(A_BANK, A_PC, p, a);
        chk("R8", "dual reg0 pulse", 32'(p), 32'h1);
        rd_chk("R8", 8'h67, 8'h28);
        fetch(B_BANK, B_PC, p, a);
        wr(8'h67, 8'h6C);
        rd_chk("R3", 8'h67, 8'h6C);
        set_cmp(1, A_BANK, A_PC);
        fetch(A_BANK, A_PC, p, a);
        chk("R8", "dual tie pulse", 32'(p), 32'h1);
        rd_chk("R8", 8'h67, 8'h2C);
        set_cmp(1, B_BANK, B_PC);
        wr(8'h67, 8'h28);
    endtask

    task automatic t_dec_hold();
        logic p, a;
        mode = 2'd2;
        fetch(B_BANK, B_PC, p, a);
        rd_chk("R9", 8'h67, 8'h68);
        mode = 2'd0;
        fetch(A_BANK, A_PC, p, a);
        chk("R9", "mode0 pulse with dec set", 32'(p), 32'h1);
        rd_chk("R9", 8'h67, 8'h68);
        mode = 2'd1;
        fetch(B_BANK, B_PC, p, a);
        rd_chk("R9", 8'h67, 8'h68);
    endtask

    task automatic t_disabled();
        logic p, a;
        wr(8'h67, 8'h08);
        mode = 2'd0;
        fetch(A_BANK, A_PC, p, a);
        chk("R10", "detect off", 32'(p), 32'h0);
        wr(8'h67, 8'h28);
        mode = 2'd3;
        fetch(A_BANK, A_PC, p, a);
        chk("R10", "mode3 reg0", 32'(p), 32'h0);
        fetch(B_BANK, B_PC, p, a);
        chk("R10", "mode3 reg1", 32'(p), 32'h0);
        rd_chk("R9", 8'h67, 8'h68);
    endtask

    task automatic t_warm();
        logic p, a;
        mode = 2'd0;
        wr(8'h67, 8'h2C);
        @(negedge clk);
        warm_rst = 1'b1;
        fetch(A_BANK, A_PC, p, a);
        chk("R2", "no irq in warm reset", 32'(p), 32'h0);
        wr(8'h67, 8'h00);
        wr(8'h68, 8'h11);
        @(negedge clk);
        warm_rst = 1'b0;
        rd_chk("R2", 8'h67, 8'h6C);
        rd_chk("R2", 8'h68, 8'h56);
        rd_chk("R2", 8'h6D, 8'h9A);
        fetch(A_BANK, A_PC, p, a);
        chk("R2", "irq after warm reset", 32'(p), 32'h1);
    endtask

    task automatic t_por_again();
        @(negedge clk);
        por_rst = 1'b1;
        repeat (2) @(negedge clk);
        por_rst = 1'b0;
        rd_chk("R1", 8'h67, 8'h00);
        wr(8'h67, 8'h0C);
        rd_chk("R1", 8'h68, 8'h00);
        rd_chk("R1", 8'h6D, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        por_rst = 1'b0;
        t_por_state();
        t_ctrl_layout();
        t_cmp_rw();
        t_locked();
        t_unmapped();
        t_mode_reg0();
        t_mode_reg1();
        t_dual();
        t_dec_hold();
        t_disabled();
        t_warm();
        t_por_again();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: run hung, actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule